// File: doc/BRIEF.md
# Shifted Address-Generation ALU

This block is a small execution unit for a 64-bit integer datapath. It computes the address-forming operations that scale an array index by 2, 4 or 8 and add a base, together with the unsigned-word forms that first take only the low 32 bits of the index operand and zero-extend them. It also provides an add of an unsigned word, which gives a plain word zero-extension when the second operand is zero, and a left shift of an unsigned word by an immediate of up to 63.

The issuing stage presents an operation code, two source operands, a shift immediate and the current state of the bit-manipulation enable bit from the machine capability register, all qualified by a request strobe. One clock later the block returns either a valid result or an illegal-instruction indication. It returns an illegal-instruction indication whenever the enable bit was clear when the request was issued. Fetch, register read, full decode and trap delivery belong to the surrounding pipeline.

Top module: `addr_shift_alu`

## Requirements
- R1: Operation codes 0, 1 and 2 return `src_a` shifted left by 1, 2 and 3 bits respectively, plus `src_b`.
- R2: Operation code 3 returns the low 32 bits of `src_a`, zero-extended, plus `src_b`. With `src_b` equal to zero this is a zero-extension of the low word.
- R3: Operation code 4 returns the low 32 bits of `src_a`, zero-extended and then shifted left at full width by `shamt` (0 to 63). The upper 32 bits of `src_a` and all of `src_b` have no effect.
- R4: Operation codes 5, 6 and 7 return the zero-extended low word of `src_a`, shifted left by 1, 2 and 3 bits respectively, plus `src_b`. The upper 32 bits of `src_a` have no effect.
- R5: All sums and shifts wrap modulo 2^64. Bits shifted or carried past bit 63 are discarded and nothing flags them.
- R6: A request issued while `bitmanip_en` is low produces `res_illegal` high, `res_valid` low and `result` zero in the following cycle.
- R7: A request issued while `bitmanip_en` is high produces `res_valid` high, `res_illegal` low and the result in the following cycle. Back-to-back requests each produce their own response.
- R8: In a cycle following one with no request, `res_valid` and `res_illegal` are low and `result` is zero. `res_valid` and `res_illegal` are never high together.
- R9: While reset is held, `res_valid` and `res_illegal` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0 to 7, see R1 to R4) |
| src_a | input | 64 | Index or value operand |
| src_b | input | 64 | Base operand |
| shamt | input | 6 | Shift immediate for operation code 4 |
| bitmanip_en | input | 1 | Bit-manipulation enable from the capability register |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_illegal | output | 1 | Illegal-instruction indication, one cycle after the request |
| result | output | 64 | Registered result, zero unless `res_valid` |

## Verification
On every cycle, the assertions check the response protocol. They check that a request answers on the next cycle with exactly one of valid or illegal, chosen by the enable bit. They check that idle cycles answer with nothing and a zero result, and that a word shift leaves zeros below the shift amount. The arithmetic itself can only be shown by the bench's scenarios. These cover each scale factor, word truncation with dirty upper bits, shift amounts at 0 and 63, the zero-base zero-extension, and carries out of bit 63. An independent model in the bench supplies the expected value for each scenario.

// File: rtl/addr_shift_alu.sv
module addr_shift_alu #(
  parameter int XLEN = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [2:0]              op,
  input  logic [XLEN-1:0]         src_a,
  input  logic [XLEN-1:0]         src_b,
  input  logic [$clog2(XLEN)-1:0] shamt,
  input  logic                    bitmanip_en,
  output logic                    res_valid,
  output logic                    res_illegal,
  output logic [XLEN-1:0]         result
);
  localparam int WORD = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  localparam logic [2:0] OP_SH1  = 3'd0;
  localparam logic [2:0] OP_SH2  = 3'd1;
  localparam logic [2:0] OP_SH3  = 3'd2;
  localparam logic [2:0] OP_ADDW = 3'd3;
  localparam logic [2:0] OP_SLLW = 3'd4;
  localparam logic [2:0] OP_SH1W = 3'd5;
  localparam logic [2:0] OP_SH2W = 3'd6;
  localparam logic [2:0] OP_SH3W = 3'd7;

  logic            word_op;
  logic [XLEN-1:0] idx;
  logic [XLEN-1:0] scaled;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] sum;
  logic            go;

  assign word_op = op[2] | (op == OP_ADDW);
  assign idx     = word_op ? {{WORD{1'b0}}, src_a[WORD-1:0]} : src_a;
  assign base    = (op == OP_SLLW) ? '0 : src_b;
  assign sum     = scaled + base;
  assign go      = req_valid && bitmanip_en;

  always_comb begin
    unique case (op)
      OP_SH1, OP_SH1W: scaled = idx << 1;
      OP_SH2, OP_SH2W: scaled = idx << 2;
      OP_SH3, OP_SH3W: scaled = idx << 3;
      OP_SLLW:         scaled = idx << shamt;
      default:         scaled = idx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_illegal <= 1'b0;
      result      <= '0;
    end else begin
      res_valid   <= go;
      res_illegal <= req_valid && !bitmanip_en;
      result      <= go ? sum : '0;
    end
  end

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_illegal));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && !res_illegal && result == '0));

  p_enabled_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bitmanip_en) |=> (res_valid && !res_illegal));

  p_disabled_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bitmanip_en) |=> (res_illegal && !res_valid && result == '0));

  p_word_shift_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bitmanip_en && op == OP_SLLW) |=>
      ((result & ((XLEN'(1) << $past(shamt)) - XLEN'(1))) == '0));

  p_word_shift_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bitmanip_en && op == OP_SLLW && shamt == SHW'(0)) |=>
      (result[XLEN-1:WORD] == '0));
endmodule

// File: tb/addr_shift_alu_test.sv
module addr_shift_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [5:0]  shamt = '0;
  logic        bitmanip_en = 1'b0;
  logic        res_valid, res_illegal;
  logic [63:0] result;

  int compared = 0;
  int mismatched = 0;
  logic [65:0] q_exp[$];
  int          q_req[$];
  bit          done = 0;

  always #4 clk = ~clk;

  addr_shift_alu uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .shamt(shamt), .bitmanip_en(bitmanip_en),
    .res_valid(res_valid), .res_illegal(res_illegal), .result(result)
  );

  function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] a,
                                        input logic [63:0] b, input logic [5:0] s);
    logic [63:0] w;
    w = 64'(a[31:0]);
    case (o)
      3'd0: return a * 64'd2 + b;
      3'd1: return a * 64'd4 + b;
      3'd2: return a * 64'd8 + b;
      3'd3: return w + b;
      3'd4: return w * (64'd1 << s);
      3'd5: return w * 64'd2 + b;
      3'd6: return w * 64'd4 + b;
      default: return w * 64'd8 + b;
    endcase
  endfunction

  task automatic issue(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [5:0] s, input logic en, input int req);
    @(negedge clk);
    req_valid = 1'b1; op = o; src_a = a; src_b = b; shamt = s; bitmanip_en = en;
    if (en) q_exp.push_back({1'b1, 1'b0, model(o, a, b, s)});
    else    q_exp.push_back({1'b0, 1'b1, 64'd0});
    q_req.push_back(req);
  endtask

  task automatic idle(input int req);
    @(negedge clk);
    req_valid = 1'b0; op = 3'd5; src_a = '1; src_b = '1; shamt = 6'd9;
    bitmanip_en = 1'b1;
    q_exp.push_back(66'd0);
    q_req.push_back(req);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      logic [65:0] e;
      int r;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      compared++;
      if ({res_valid, res_illegal, result} !== e) begin
        mismatched++;
        $display("FAIL R%0d: got valid=%b illegal=%b result=%h, expected valid=%b illegal=%b result=%h",
                 r, res_valid, res_illegal, result, e[65], e[64], e[63:0]);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          mismatched++;
          $display("FAIL watchdog: got no completion, expected completion");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
          $finish;
        end
      end
    join_none

    // R9: outputs quiet while reset is held, even with a request present
    req_valid = 1'b1; bitmanip_en = 1'b1; src_a = 64'h55; src_b = 64'h1;
    repeat (3) @(posedge clk);
    #2;
    compared++;
    if (res_valid !== 1'b0 || res_illegal !== 1'b0 || result !== 64'd0) begin
      mismatched++;
      $display("FAIL R9: got valid=%b illegal=%b result=%h, expected 0 0 0",
               res_valid, res_illegal, result);
    end
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b1;

    // R1: scaled index plus base
    issue(3'd0, 64'h0000_0000_0000_1000, 64'h0000_0000_8000_0000, 6'd0, 1'b1, 1);
    issue(3'd1, 64'h1234_5678_9abc_def0, 64'h10, 6'd0, 1'b1, 1);
    issue(3'd2, 64'h0000_0000_0000_0007, 64'hffff_0000_0000_0000, 6'd0, 1'b1, 1);
    // R2: unsigned word add, dirty upper half; base zero gives zero-extend
    issue(3'd3, 64'hdead_beef_ffff_ffff, 64'h1, 6'd0, 1'b1, 2);
    issue(3'd3, 64'hcafe_f00d_8000_0001, 64'h0, 6'd0, 1'b1, 2);
    // R3: word shift left by immediate, boundaries 0 and 63, src_b ignored
    issue(3'd4, 64'hffff_ffff_8765_4321, 64'h1111_2222_3333_4444, 6'd0, 1'b1, 3);
    issue(3'd4, 64'hffff_ffff_8765_4321, 64'h1111_2222_3333_4444, 6'd32, 1'b1, 3);
    issue(3'd4, 64'h0000_0000_0000_0003, 64'hffff, 6'd63, 1'b1, 3);
    issue(3'd4, 64'h0000_0001_0000_0000, 64'h0, 6'd5, 1'b1, 3);
    // R4: scaled unsigned word plus base
    issue(3'd5, 64'hffff_ffff_ffff_ffff, 64'h0, 6'd0, 1'b1, 4);
    issue(3'd6, 64'h8000_0000_4000_0000, 64'h100, 6'd0, 1'b1, 4);
    issue(3'd7, 64'h0123_4567_ffff_fff0, 64'h8, 6'd0, 1'b1, 4);
    // R5: wrap past bit 63
    issue(3'd2, 64'hffff_ffff_ffff_ffff, 64'h9, 6'd0, 1'b1, 5);
    issue(3'd0, 64'h8000_0000_0000_0001, 64'hffff_ffff_ffff_ffff, 6'd0, 1'b1, 5);
    issue(3'd3, 64'hffff_ffff, 64'hffff_ffff_ffff_fff0, 6'd0, 1'b1, 5);
    // R8: idle gap
    idle(8);
    idle(8);
    // R6: enable clear raises illegal instead of a result
    issue(3'd1, 64'h40, 64'h4, 6'd0, 1'b0, 6);
    issue(3'd4, 64'hffff, 64'h0, 6'd8, 1'b0, 6);
    // R7: enable toggling back-to-back
    issue(3'd7, 64'h2, 64'h3, 6'd0, 1'b1, 7);
    issue(3'd7, 64'h2, 64'h3, 6'd0, 1'b0, 7);
    issue(3'd6, 64'h2, 64'h3, 6'd0, 1'b1, 7);
    for (int i = 0; i < 8; i++)
      issue(3'(i), 64'h0f0f_0f0f_f0f0_f0f0 + 64'(i), 64'(i * 3), 6'(i * 7), 1'b1, 7);
    idle(8);
    idle(8);
    while (q_exp.size() > 0) @(posedge clk);
    #3;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule